// File: doc/BRIEF.md
# SMBus Block-Transfer Host Register File

This block is the byte-wide register window of an SMBus host controller that carries out block reads and block writes. Software sees eight byte registers on a four-bit address: a status byte with write-one-to-clear flags, a control byte that selects the protocol and launches a transfer, a command byte, a target address byte with the direction in its low bit, two data bytes and an auxiliary control byte. A single data port in front of a 32-entry byte buffer walks through the buffer on each access. The walk starts from zero after any read of the control byte.

Setting the start bit with the block protocol selected hands the transfer to a sequencer. The sequencer drives a lower-level byte engine through a request/acknowledge handshake, one byte operation at a time: start condition, write byte, read byte or stop condition. It fills in the status flags when the transfer ends. On a block write, the byte count comes from data register 0 and the payload from the buffer. On a block read, the count returned by the target lands in data register 0 and the payload lands in the buffer. Software clears the buffer index and then drains the payload through the data port.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every readable register reads 0x00, the engine request `eng_req` is low and the buffer index is zero.
- R2: Address 0x3 (command), 0x4 (target address), 0x5 (data 0) and 0x6 (data 1) read back what was written. Address 0xD keeps only bits [1:0] and reads 0 elsewhere. Address 0x2 keeps bits 0, [4:2], 5 and 7; the start bit 6 and the kill bit 1 always read 0.
- R3: When auxiliary bit 1 is set, each read or write of address 0x7 moves the buffer index up by one. When that bit is clear, the index stays at 0. A read of address 0x2 returns the index to 0.
- R4: A control write with bit 6 set and bits [4:2] = 3'b101, made while idle, starts a transfer. Status bit 0 (busy) reads 1 from the next cycle until the transfer ends. A start with any other protocol value is ignored.
- R5: Engine ops are encoded 00 start, 01 write, 10 read, 11 stop, and each request is held until `eng_ack`. A block write (target address bit 0 = 0) issues: start, write {addr[7:1],0}, write command, write count, one write per payload byte from buffer entry 0 upward, then stop.
- R6: A block read (target address bit 0 = 1) issues: start, write {addr[7:1],0}, write command, start, write {addr[7:1],1}, read count, one read per payload byte, then stop. `eng_nack_out` is high only on the last payload read. The count goes to data 0, and the payload can be read in order through address 0x7.
- R7: Status bit 1 is set only when a transfer completes without error.
- R8: A block write whose count is 0 or greater than 32 sets status bit 2 and issues no engine operation. A received count of 0 or greater than 32 sets status bit 2 and is followed directly by stop.
- R9: A target NACK on any written byte sets status bit 2, and stop is the next operation.
- R10: A control write with bit 1 set during a transfer drops `eng_req` at once, sets status bit 4 and clears busy.
- R11: A start written while busy has no effect on the transfer in progress.
- R12: Writing 1 to status bits 1, 2 or 4 clears that bit. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| eng_req | output | 1 | Byte operation request, held until acknowledge |
| eng_op | output | 2 | Byte operation code |
| eng_wdata | output | 8 | Byte to send on a write operation |
| eng_nack_out | output | 1 | Host NACKs the byte of this read operation |
| eng_ack | input | 1 | One-cycle operation completion |
| eng_rx_nack | input | 1 | Target NACKed the written byte (valid with ack) |
| eng_rdata | input | 8 | Byte received on a read operation (valid with ack) |

## Verification
The hardest case to reach is a kill that lands while the engine is partway through a long payload. The bench starts a 32-byte write and issues the kill a few cycles later, while requests are still outstanding. It then checks that the request drops, that the failed flag is set and that busy is cleared. Received counts of 0 and 33 come from the bench's engine model, which returns a programmed count byte. NACK placement is set by giving the index of the operation to refuse. Block lengths 1 to 32 are swept in both directions, and the operation trace is compared with the expected sequence computed from the length.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_STOP  = 2'b11
    } eng_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_AW, S_CMD, S_CNTW, S_DW,
        S_RS, S_AR, S_CNTR, S_DR, S_STOP
    } seq_state_e;

    localparam logic [3:0] A_STAT  = 4'h0;
    localparam logic [3:0] A_CTRL  = 4'h2;
    localparam logic [3:0] A_CMD   = 4'h3;
    localparam logic [3:0] A_XADDR = 4'h4;
    localparam logic [3:0] A_DAT0  = 4'h5;
    localparam logic [3:0] A_DAT1  = 4'h6;
    localparam logic [3:0] A_BLK   = 4'h7;
    localparam logic [3:0] A_AUX   = 4'hD;

    localparam logic [2:0] PROTO_BLOCK = 3'b101;

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
    parameter int DEPTH = 32,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [7:0]      wdata,
    input  logic [IDXW-1:0] raddr_a,
    output logic [7:0]      rdata_a,
    input  logic [IDXW-1:0] raddr_b,
    output logic [7:0]      rdata_b
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/smbus_blk_seq.sv
module smbus_blk_seq
    import smbus_host_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            kill,
    input  logic [7:0]      xaddr,
    input  logic [7:0]      cmd,
    input  logic [7:0]      wr_cnt,
    input  logic [7:0]      buf_rdata,
    output logic [IDXW-1:0] buf_idx,
    output logic            buf_we,
    output logic [7:0]      buf_wdata,
    output logic            cnt_we,
    output logic [7:0]      cnt_val,
    output logic            busy,
    output logic            done_ok,
    output logic            dev_err,
    output logic            killed,
    output logic            eng_req,
    output logic [1:0]      eng_op,
    output logic [7:0]      eng_wdata,
    output logic            eng_nack_out,
    input  logic            eng_ack,
    input  logic            eng_rx_nack,
    input  logic [7:0]      eng_rdata
);
    typedef struct packed {
        seq_state_e    st;
        logic [IDXW:0] idx;
        logic [7:0]    cnt;
        logic          err;
    } seq_t;

    seq_t q, d;
    logic [IDXW:0] idx_nx;
    logic          last;

    function automatic logic bad_count(input logic [7:0] c);
        return (c == 8'd0) || (c > 8'(DEPTH));
    endfunction

    assign idx_nx  = q.idx + 1'b1;
    assign last    = (8'(idx_nx) == q.cnt);
    assign buf_idx = q.idx[IDXW-1:0];

    always_comb begin
        d            = q;
        buf_we       = 1'b0;
        cnt_we       = 1'b0;
        done_ok      = 1'b0;
        dev_err      = 1'b0;
        killed       = 1'b0;
        buf_wdata    = eng_rdata;
        cnt_val      = eng_rdata;
        eng_req      = (q.st != S_IDLE);
        busy         = (q.st != S_IDLE);
        eng_nack_out = (q.st == S_DR) && last;
        eng_op       = OP_WRITE;
        eng_wdata    = 8'h00;
        case (q.st)
            S_START, S_RS: eng_op = OP_START;
            S_AW:   eng_wdata = {xaddr[7:1], 1'b0};
            S_CMD:  eng_wdata = cmd;
            S_CNTW: eng_wdata = q.cnt;
            S_DW:   eng_wdata = buf_rdata;
            S_AR:   eng_wdata = {xaddr[7:1], 1'b1};
            S_CNTR, S_DR: eng_op = OP_READ;
            S_STOP: eng_op = OP_STOP;
            default: ;
        endcase

        if (q.st == S_IDLE) begin
            if (go) begin
                if (!xaddr[0] && bad_count(wr_cnt)) begin
                    dev_err = 1'b1;
                end else begin
                    d.st  = S_START;
                    d.cnt = wr_cnt;
                    d.idx = '0;
                    d.err = 1'b0;
                end
            end
        end else if (eng_ack) begin
            if (eng_op == OP_WRITE && eng_rx_nack) begin
                d.err = 1'b1;
                d.st  = S_STOP;
            end else begin
                case (q.st)
                    S_START: d.st = S_AW;
                    S_AW:    d.st = S_CMD;
                    S_CMD:   d.st = xaddr[0] ? S_RS : S_CNTW;
                    S_CNTW:  begin d.st = S_DW; d.idx = '0; end
                    S_DW: begin
                        d.idx = idx_nx;
                        if (last) d.st = S_STOP;
                    end
                    S_RS:    d.st = S_AR;
                    S_AR:    d.st = S_CNTR;
                    S_CNTR: begin
                        cnt_we = 1'b1;
                        d.cnt  = eng_rdata;
                        d.idx  = '0;
                        if (bad_count(eng_rdata)) begin
                            d.err = 1'b1;
                            d.st  = S_STOP;
                        end else begin
                            d.st  = S_DR;
                        end
                    end
                    S_DR: begin
                        buf_we = 1'b1;
                        d.idx  = idx_nx;
                        if (last) d.st = S_STOP;
                    end
                    S_STOP: begin
                        d.st    = S_IDLE;
                        done_ok = !q.err;
                        dev_err = q.err;
                    end
                    default: d.st = S_IDLE;
                endcase
            end
        end

        if (kill && q.st != S_IDLE) begin
            d.st    = S_IDLE;
            killed  = 1'b1;
            done_ok = 1'b0;
            dev_err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, idx: '0, cnt: '0, err: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbus_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       eng_req,
    output logic [1:0] eng_op,
    output logic [7:0] eng_wdata,
    output logic       eng_nack_out,
    input  logic       eng_ack,
    input  logic       eng_rx_nack,
    input  logic [7:0] eng_rdata
);
    localparam int IDXW = $clog2(BUF_DEPTH);

    typedef struct packed {
        logic            intr;
        logic            deverr;
        logic            failed;
        logic            intren;
        logic [2:0]      proto;
        logic            lastb;
        logic            pec;
        logic [7:0]      cmd;
        logic [7:0]      xaddr;
        logic [7:0]      dat0;
        logic [7:0]      dat1;
        logic [1:0]      aux;
        logic [IDXW-1:0] pidx;
    } regs_t;

    regs_t q, d;

    logic            seq_busy, seq_ok, seq_err, seq_killed;
    logic            seq_buf_we, seq_cnt_we;
    logic [7:0]      seq_buf_wdata, seq_cnt_val, seq_buf_rdata, port_rdata;
    logic [IDXW-1:0] seq_idx;
    logic            go, kill, wr_ctrl, blk_acc;
    logic            buf_we;
    logic [IDXW-1:0] buf_waddr;
    logic [7:0]      buf_wdata;
    logic            st_intr, st_deverr, st_failed;

    assign st_intr   = q.intr;
    assign st_deverr = q.deverr;
    assign st_failed = q.failed;

    assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
    assign go      = wr_ctrl && reg_wdata[6] && !seq_busy && reg_wdata[4:2] == PROTO_BLOCK;
    assign kill    = wr_ctrl && reg_wdata[1];
    assign blk_acc = (reg_wr || reg_rd) && reg_addr == A_BLK;

    always_comb begin
        buf_we    = seq_buf_we || (reg_wr && reg_addr == A_BLK);
        buf_waddr = seq_buf_we ? seq_idx : q.pidx;
        buf_wdata = seq_buf_we ? seq_buf_wdata : reg_wdata;
    end

    smbus_blk_buf #(.DEPTH(BUF_DEPTH), .IDXW(IDXW)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr_a(q.pidx), .rdata_a(port_rdata),
        .raddr_b(seq_idx), .rdata_b(seq_buf_rdata)
    );

    smbus_blk_seq #(.DEPTH(BUF_DEPTH), .IDXW(IDXW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .kill(kill),
        .xaddr(q.xaddr), .cmd(q.cmd), .wr_cnt(q.dat0),
        .buf_rdata(seq_buf_rdata), .buf_idx(seq_idx), .buf_we(seq_buf_we),
        .buf_wdata(seq_buf_wdata), .cnt_we(seq_cnt_we), .cnt_val(seq_cnt_val),
        .busy(seq_busy), .done_ok(seq_ok), .dev_err(seq_err), .killed(seq_killed),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_nack_out(eng_nack_out), .eng_ack(eng_ack),
        .eng_rx_nack(eng_rx_nack), .eng_rdata(eng_rdata)
    );

    always_comb begin
        d = q;
        if (reg_wr && reg_addr == A_STAT) begin
            if (reg_wdata[1]) d.intr   = 1'b0;
            if (reg_wdata[2]) d.deverr = 1'b0;
            if (reg_wdata[4]) d.failed = 1'b0;
        end
        if (seq_ok)     d.intr   = 1'b1;
        if (seq_err)    d.deverr = 1'b1;
        if (seq_killed) d.failed = 1'b1;

        if (wr_ctrl) begin
            d.intren = reg_wdata[0];
            d.proto  = reg_wdata[4:2];
            d.lastb  = reg_wdata[5];
            d.pec    = reg_wdata[7];
        end
        if (reg_wr) begin
            case (reg_addr)
                A_CMD:   d.cmd   = reg_wdata;
                A_XADDR: d.xaddr = reg_wdata;
                A_DAT0:  d.dat0  = reg_wdata;
                A_DAT1:  d.dat1  = reg_wdata;
                A_AUX:   d.aux   = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (seq_cnt_we) d.dat0 = seq_cnt_val;

        if (reg_rd && reg_addr == A_CTRL) d.pidx = '0;
        else if (blk_acc && q.aux[1])     d.pidx = q.pidx + 1'b1;
    end

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = {3'b000, st_failed, 1'b0, st_deverr, st_intr, seq_busy};
            A_CTRL:  reg_rdata = {q.pec, 1'b0, q.lastb, q.proto, 1'b0, q.intren};
            A_CMD:   reg_rdata = q.cmd;
            A_XADDR: reg_rdata = q.xaddr;
            A_DAT0:  reg_rdata = q.dat0;
            A_DAT1:  reg_rdata = q.dat1;
            A_BLK:   reg_rdata = port_rdata;
            A_AUX:   reg_rdata = {6'b0, q.aux};
            default: reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       eng_req,
    input logic       eng_ack,
    input logic [1:0] eng_op,
    input logic       eng_nack_out,
    input logic       st_intr,
    input logic       st_deverr,
    input logic       st_failed
);
    logic kill_wr, start_wr;
    assign kill_wr  = reg_wr && reg_addr == 4'h2 && reg_wdata[1];
    assign start_wr = reg_wr && reg_addr == 4'h2 && reg_wdata[6];

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack && !kill_wr) |=> (eng_req && $stable(eng_op)));

    p_nack_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack_out |-> (eng_req && eng_op == 2'b10));

    p_req_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(start_wr));

    p_ok_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(st_intr) && $rose(st_deverr)));

    p_kill_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_wr && eng_req) |=> (!eng_req && st_failed));

    p_w1c_intr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0 && reg_wdata[1] && !eng_req) |=> !st_intr);
endmodule

bind smbus_host_regs smbus_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .eng_req(eng_req), .eng_ack(eng_ack),
    .eng_op(eng_op), .eng_nack_out(eng_nack_out),
    .st_intr(st_intr), .st_deverr(st_deverr), .st_failed(st_failed)
);

// File: tb/sim_smbus_host_regs.sv
module sim_smbus_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_nack_out;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic       eng_ack = 1'b0, eng_rx_nack = 1'b0;
    logic [7:0] eng_rdata = 8'h00;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    smbus_host_regs u0 (.*);

    // engine model
    int op_n = 0, rd_i = 0;
    int op_base = 0, rd_base = 0, nack_at = -1;
    logic [7:0] rd_cnt = 8'd0;
    logic [1:0] tr_op [64];
    logic [7:0] tr_dat[64];
    logic       tr_nk [64];

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'((i * 37 + 11)) ^ s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_ack <= 1'b0;
        end else if (eng_req && !eng_ack) begin
            eng_ack <= 1'b1;
            if (op_n - op_base < 64 && op_n >= op_base) begin
                tr_op[op_n - op_base]  <= eng_op;
                tr_dat[op_n - op_base] <= eng_wdata;
                tr_nk[op_n - op_base]  <= eng_nack_out;
            end
            eng_rx_nack <= (op_n - op_base == nack_at);
            eng_rdata   <= (rd_i == rd_base) ? rd_cnt : pat(rd_i - rd_base - 1, rd_cnt);
            if (eng_op == 2'b10) rd_i <= rd_i + 1;
            op_n <= op_n + 1;
        end else begin
            eng_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 2000; k++) begin
            rd(4'h0, s);
            if (!s[0]) return;
        end
    endtask

    task automatic mark();
        op_base = op_n;
        rd_base = rd_i;
    endtask

    function automatic int trace_err(input int i, input logic [1:0] op, input logic [7:0] dat,
                                     input bit check_dat);
        if (tr_op[i] != op) return 1;
        if (check_dat && tr_dat[i] != dat) return 1;
        return 0;
    endfunction

    initial begin
        logic [7:0] v;
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk("R1 status", v, 8'h00);
        rd(4'h2, v); chk("R1 ctrl", v, 8'h00);
        rd(4'h5, v); chk("R1 data0", v, 8'h00);
        rd(4'hD, v); chk("R1 aux", v, 8'h00);
        chk("R1 eng_req", eng_req, 0);

        // R2 register map
        wr(4'h3, 8'hA5); rd(4'h3, v); chk("R2 cmd", v, 8'hA5);
        wr(4'h4, 8'h3C); rd(4'h4, v); chk("R2 xaddr", v, 8'h3C);
        wr(4'h5, 8'h81); rd(4'h5, v); chk("R2 data0", v, 8'h81);
        wr(4'h6, 8'h7E); rd(4'h6, v); chk("R2 data1", v, 8'h7E);
        wr(4'hD, 8'hFF); rd(4'hD, v); chk("R2 aux", v, 8'h03);
        mark();
        wr(4'h2, 8'hFF); rd(4'h2, v); chk("R2 ctrl start/kill read 0", v, 8'hBD);
        wr(4'h2, 8'h00);

        // R4 non-block protocol start ignored
        wr(4'h4, 8'h50); wr(4'h5, 8'd4); mark();
        wr(4'h2, 8'h48);
        rd(4'h0, v); chk("R4 other protocol no busy", v, 8'h00);
        repeat (5) @(negedge clk);
        chk("R4 other protocol no ops", op_n - op_base, 0);

        // R3 index behaviour
        wr(4'hD, 8'h00); rd(4'h2, v);
        wr(4'h7, 8'h11); wr(4'h7, 8'h22); rd(4'h2, v);
        rd(4'h7, v); chk("R3 narrow mode holds index", v, 8'h22);
        rd(4'h7, v); chk("R3 narrow mode holds index on read", v, 8'h22);
        wr(4'hD, 8'h02); rd(4'h2, v);
        wr(4'h7, 8'h11); wr(4'h7, 8'h22); rd(4'h2, v);
        rd(4'h7, v); chk("R3 wide mode entry 0", v, 8'h11);
        rd(4'h7, v); chk("R3 wide mode entry 1", v, 8'h22);

        // R5 R7 block write sweep
        for (int len = 1; len <= 32; len++) begin
            wr(4'h4, 8'h50); wr(4'h3, 8'(len + 100)); wr(4'h5, 8'(len));
            rd(4'h2, v);
            for (int i = 0; i < len; i++) wr(4'h7, 8'(i * 13 + len));
            nack_at = -1; mark();
            wr(4'h2, 8'h54);
            rd(4'h0, v); chk("R4 busy after start", v[0], 1);
            wait_idle();
            rd(4'h0, v); chk("R7 write success status", v, 8'h02);
            e = 0;
            if (op_n - op_base != len + 5) e++;
            e += trace_err(0, 2'b00, 8'h00, 0);
            e += trace_err(1, 2'b01, 8'h50, 1);
            e += trace_err(2, 2'b01, 8'(len + 100), 1);
            e += trace_err(3, 2'b01, 8'(len), 1);
            for (int i = 0; i < len; i++) e += trace_err(4 + i, 2'b01, 8'(i * 13 + len), 1);
            e += trace_err(len + 4, 2'b11, 8'h00, 0);
            chk($sformatf("R5 write trace len %0d", len), e, 0);
            wr(4'h0, 8'hFF);
        end

        // R6 block read sweep
        for (int n = 1; n <= 32; n++) begin
            wr(4'h4, 8'h51); wr(4'h3, 8'h20);
            rd_cnt = 8'(n); nack_at = -1; mark();
            wr(4'h2, 8'h54);
            wait_idle();
            rd(4'h0, v); chk("R7 read success status", v, 8'h02);
            rd(4'h5, v); chk("R6 count in data0", v, n);
            e = 0;
            if (op_n - op_base != n + 7) e++;
            e += trace_err(0, 2'b00, 8'h00, 0);
            e += trace_err(1, 2'b01, 8'h50, 1);
            e += trace_err(2, 2'b01, 8'h20, 1);
            e += trace_err(3, 2'b00, 8'h00, 0);
            e += trace_err(4, 2'b01, 8'h51, 1);
            e += trace_err(5, 2'b10, 8'h00, 0);
            if (tr_nk[5]) e++;
            for (int i = 0; i < n; i++) begin
                e += trace_err(6 + i, 2'b10, 8'h00, 0);
                if (tr_nk[6 + i] != (i == n - 1)) e++;
            end
            e += trace_err(n + 6, 2'b11, 8'h00, 0);
            chk($sformatf("R6 read trace count %0d", n), e, 0);
            rd(4'h2, v);
            e = 0;
            for (int i = 0; i < n; i++) begin
                rd(4'h7, v);
                if (v != pat(i, 8'(n))) e++;
            end
            chk($sformatf("R6 read payload count %0d", n), e, 0);
            wr(4'h0, 8'hFF);
        end

        // R8 bad received counts
        foreach (tr_op[k]) tr_op[k] = 2'b00;
        for (int b = 0; b < 2; b++) begin
            wr(4'h4, 8'h51);
            rd_cnt = (b == 0) ? 8'd0 : 8'd33; nack_at = -1; mark();
            wr(4'h2, 8'h54);
            wait_idle();
            rd(4'h0, v); chk("R8 bad rx count dev err", v, 8'h04);
            chk("R8 bad rx count op total", op_n - op_base, 7);
            chk("R8 stop after count", tr_op[6], 2'b11);
            wr(4'h0, 8'hFF);
        end

        // R8 bad write counts
        for (int b = 0; b < 2; b++) begin
            wr(4'h4, 8'h50); wr(4'h5, (b == 0) ? 8'd0 : 8'd33); mark();
            wr(4'h2, 8'h54);
            repeat (6) @(negedge clk);
            rd(4'h0, v); chk("R8 bad write count dev err", v, 8'h04);
            chk("R8 bad write count no ops", op_n - op_base, 0);
            wr(4'h0, 8'hFF);
        end

        // R9 NACK on address and on a payload byte
        wr(4'h4, 8'h50); wr(4'h5, 8'd3); nack_at = 1; mark();
        wr(4'h2, 8'h54);
        wait_idle();
        rd(4'h0, v); chk("R9 addr nack dev err", v, 8'h04);
        chk("R9 addr nack op total", op_n - op_base, 3);
        chk("R9 stop follows nack", tr_op[2], 2'b11);
        wr(4'h0, 8'hFF);
        nack_at = 5; mark();
        wr(4'h2, 8'h54);
        wait_idle();
        rd(4'h0, v); chk("R9 data nack dev err", v, 8'h04);
        chk("R9 data nack op total", op_n - op_base, 7);
        wr(4'h0, 8'hFF); nack_at = -1;

        // R11 start while busy ignored
        wr(4'h4, 8'h51); rd_cnt = 8'd4; mark();
        wr(4'h2, 8'h54);
        wr(4'h2, 8'h54);
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R11 second start no extra ops", op_n - op_base, 11);
        rd(4'h0, v); chk("R11 status after", v, 8'h02);

        // R12 selective W1C
        wr(4'h0, 8'h04); rd(4'h0, v); chk("R12 write 0 keeps intr", v, 8'h02);
        wr(4'h0, 8'h02); rd(4'h0, v); chk("R12 write 1 clears intr", v, 8'h00);

        // R10 kill during long write
        wr(4'h4, 8'h50); wr(4'h5, 8'd32); mark();
        wr(4'h2, 8'h54);
        repeat (8) @(negedge clk);
        chk("R10 busy before kill", eng_req, 1);
        wr(4'h2, 8'h02);
        chk("R10 request dropped", eng_req, 0);
        rd(4'h0, v); chk("R10 failed set busy clear", v, 8'h10);
        wr(4'h0, 8'h10); rd(4'h0, v); chk("R12 clear failed", v, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule